// File: doc/BRIEF.md
# Receive CRC Inclusion Controller

This block sits beside a serial receiver and folds received characters into a 16-bit CRC register. Each time the receiver hands a completed byte to its FIFO, the block is told through a transfer strobe. If the CRC enable is high in that cycle, the byte is latched and its bits are folded in one at a time on the following receive bit strobes, least significant bit first. Eight bit strobes later the byte is fully accounted for. The block never looks at FIFO occupancy. Because the enable is sampled only at the transfer, firmware drops a byte from the CRC by clearing the enable before that byte is handed over.

Two polynomials are selectable, CRC-16 and CCITT, both processed in reflected (shift-right) form. A clear input presets the register for the selected polynomial. A good-check flag reports a zero remainder, which is what appears after a frame whose trailing check bytes were the register value sent low byte first, LSB first. Characters must be 8 bits wide for the one-byte pipeline to line up.

Top module: `rx_crc_incl`

## Requirements
- R1: After reset, crc_o is 0x0000 and no byte is pending, so bit strobes leave crc_o unchanged.
- R2: A clear presets crc_o on the next cycle to 0xFFFF when poly_sel_i=1 (CCITT) or 0x0000 when poly_sel_i=0 (CRC-16), and it abandons any byte still pending. Clear takes priority over a transfer in the same cycle.
- R3: A transfer with crc_en_i=1 latches rx_byte_i. Each of the next 8 bit strobes folds in one bit, starting with bit 0, and updates crc_o one cycle later as crc = (crc>>1) ^ (fb ? P : 0), where fb = crc[0] ^ bit, P = 0xA001 for CRC-16 and P = 0x8408 for CCITT.
- R4: A transfer with crc_en_i=0 excludes that byte: crc_o stays unchanged through the bit strobes that follow it.
- R5: Once the eighth bit of a byte has been folded, further bit strobes have no effect until the next enabled transfer.
- R6: crc_o holds in any cycle without a bit strobe. A bit strobe in the same cycle as a transfer or a clear is ignored.
- R7: A transfer that arrives before the previous byte's eight steps are done abandons that byte's remaining bits. An enabled new byte starts again from its bit 0; a disabled one leaves the block idle.
- R8: crc_ok_o is 1 exactly when crc_o is 0x0000. Appending the register value low byte first to the bytes it covered brings crc_o to 0x0000 for either polynomial.
- R9: Changing crc_en_i between transfers does not affect the byte being processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_i | input | 1 | Byte handed from the shift register to the FIFO |
| rx_byte_i | input | 8 | Byte being handed over |
| crc_en_i | input | 1 | Include the byte transferred in this cycle |
| bit_stb_i | input | 1 | Receive bit time strobe |
| crc_clear_i | input | 1 | Preset the CRC register |
| poly_sel_i | input | 1 | 0 = CRC-16, 1 = CCITT |
| crc_o | output | 16 | Running CRC register |
| crc_ok_o | output | 1 | Register holds zero remainder |

## Verification
A clear or a bit strobe registered at one rising edge shows on crc_o from that edge onward. A transfer only loads the pending byte, so crc_o moves first on the edge of the first bit strobe after it. The bench drives every input on falling edges and reads crc_o and crc_ok_o on the next falling edge. It counts strobes explicitly, so partial bytes (seven steps, three steps before a restart) are compared against the reflected-shift model at the exact step reached. crc_ok_o is combinational on the register and is read in the same half cycle as crc_o.

// File: rtl/rx_crc_pkg.sv
package rx_crc_pkg;
  localparam int CRC_W = 16;

  typedef enum logic {
    POLY_CRC16 = 1'b0,
    POLY_CCITT = 1'b1
  } poly_e;

  localparam logic [CRC_W-1:0] POLY_CRC16_REFL = 16'hA001;
  localparam logic [CRC_W-1:0] POLY_CCITT_REFL = 16'h8408;

  function automatic logic [CRC_W-1:0] crc_preset(poly_e p);
    return (p == POLY_CCITT) ? '1 : '0;
  endfunction

  function automatic logic [CRC_W-1:0] crc_bit_step(logic [CRC_W-1:0] c, logic b, poly_e p);
    logic [CRC_W-1:0] tap;
    tap = (p == POLY_CCITT) ? POLY_CCITT_REFL : POLY_CRC16_REFL;
    return (c >> 1) ^ ((c[0] ^ b) ? tap : '0);
  endfunction
endpackage

// File: rtl/rx_crc_seq.sv
module rx_crc_seq #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              xfer_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              bit_stb_i,
  output logic              step_o,
  output logic              bit_o,
  output logic              busy_o
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;

  // strobes coinciding with clear or transfer are dropped
  assign step_o = busy_q & bit_stb_i & ~xfer_i & ~clear_i;
  assign bit_o  = sh_q[0];
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (clear_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (xfer_i) begin
      busy_q <= en_i;
      sh_q   <= data_i;
      cnt_q  <= '0;
    end else if (step_o) begin
      sh_q  <= sh_q >> 1;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_crc_reg.sv
module rx_crc_reg
  import rx_crc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  poly_e            poly_i,
  input  logic             step_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clear_i) crc_q <= crc_preset(poly_i);
    else if (step_i)  crc_q <= crc_bit_step(crc_q, bit_i, poly_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/rx_crc_incl.sv
module rx_crc_incl
  import rx_crc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              crc_en_i,
  input  logic              bit_stb_i,
  input  logic              crc_clear_i,
  input  logic              poly_sel_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              crc_ok_o
);
  logic seq_step, seq_bit, seq_busy;
  poly_e poly;

  assign poly = poly_e'(poly_sel_i);

  rx_crc_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (crc_clear_i),
    .xfer_i    (xfer_i),
    .en_i      (crc_en_i),
    .data_i    (rx_byte_i),
    .bit_stb_i (bit_stb_i),
    .step_o    (seq_step),
    .bit_o     (seq_bit),
    .busy_o    (seq_busy)
  );

  rx_crc_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (crc_clear_i),
    .poly_i  (poly),
    .step_i  (seq_step),
    .bit_i   (seq_bit),
    .crc_o   (crc_o)
  );

  assign crc_ok_o = (crc_o == '0);
endmodule

// File: rtl/rx_crc_incl_chk.sv
module rx_crc_incl_chk #(
  parameter int BYTE_W = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        xfer_i,
  input logic        crc_en_i,
  input logic        bit_stb_i,
  input logic        crc_clear_i,
  input logic        poly_sel_i,
  input logic [15:0] crc_o,
  input logic        busy_i,
  input logic        step_i
);
  logic [7:0] steps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   steps_q <= '0;
    else if (xfer_i || crc_clear_i) steps_q <= '0;
    else if (step_i && steps_q != 8'hFF) steps_q <= steps_q + 1'b1;
  end

  p_clear_preset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_clear_i |=> crc_o == ($past(poly_sel_i) ? 16'hFFFF : 16'h0000));

  p_clear_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_clear_i |=> !busy_i);

  p_excluded_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && !crc_en_i && !crc_clear_i |=> !busy_i);

  p_byte_steps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steps_q <= 8'(BYTE_W));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_i && !crc_clear_i |=> $stable(crc_o));

  p_xfer_blocks_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && !crc_clear_i |=> $stable(crc_o));
endmodule

bind rx_crc_incl rx_crc_incl_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .xfer_i      (xfer_i),
  .crc_en_i    (crc_en_i),
  .bit_stb_i   (bit_stb_i),
  .crc_clear_i (crc_clear_i),
  .poly_sel_i  (poly_sel_i),
  .crc_o       (crc_o),
  .busy_i      (seq_busy),
  .step_i      (seq_step)
);

// File: tb/rx_crc_incl_test.sv
module rx_crc_incl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xfer_i = 1'b0;
  logic [7:0]  rx_byte_i = '0;
  logic        crc_en_i = 1'b0;
  logic        bit_stb_i = 1'b0;
  logic        crc_clear_i = 1'b0;
  logic        poly_sel_i = 1'b0;
  logic [15:0] crc_o;
  logic        crc_ok_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rx_crc_incl uut (
    .clk_i, .rst_ni, .xfer_i, .rx_byte_i, .crc_en_i,
    .bit_stb_i, .crc_clear_i, .poly_sel_i, .crc_o, .crc_ok_o
  );

  function automatic logic [15:0] m_step(logic [15:0] c, logic b, logic p);
    logic [15:0] tap;
    tap = p ? 16'h8408 : 16'hA001;
    return (c >> 1) ^ ((c[0] ^ b) ? tap : 16'h0000);
  endfunction

  function automatic logic [15:0] m_bits(logic [15:0] c, logic [7:0] d, int n, logic p);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < n; i++) r = m_step(r, d[i], p);
    return r;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_clear(logic p);
    @(negedge clk_i);
    poly_sel_i = p;
    crc_clear_i = 1'b1;
    @(negedge clk_i);
    crc_clear_i = 1'b0;
  endtask

  task automatic do_xfer(logic [7:0] d, logic en);
    @(negedge clk_i);
    xfer_i = 1'b1; rx_byte_i = d; crc_en_i = en;
    @(negedge clk_i);
    xfer_i = 1'b0;
  endtask

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      bit_stb_i = 1'b1;
      @(negedge clk_i);
      bit_stb_i = 1'b0;
    end
  endtask

  task automatic t_reset;
    check("R1 reset crc", crc_o, 16'h0000);
    check("R1 reset ok", {15'd0, crc_ok_o}, 16'd1);
    strobes(3);
    check("R1 idle strobes", crc_o, 16'h0000);
  endtask

  task automatic t_clear;
    do_clear(1'b1);
    check("R2 ccitt preset", crc_o, 16'hFFFF);
    check("R8 ok low nonzero", {15'd0, crc_ok_o}, 16'd0);
    do_clear(1'b0);
    check("R2 crc16 preset", crc_o, 16'h0000);
  endtask

  task automatic t_single;
    do_clear(1'b0);
    do_xfer(8'h5A, 1'b1);
    check("R3 no change at transfer", crc_o, 16'h0000);
    strobes(7);
    check("R3 seven bits", crc_o, m_bits(16'h0000, 8'h5A, 7, 1'b0));
    strobes(1);
    check("R3 full byte", crc_o, m_bits(16'h0000, 8'h5A, 8, 1'b0));
    strobes(4);
    check("R5 extra strobes", crc_o, m_bits(16'h0000, 8'h5A, 8, 1'b0));
  endtask

  task automatic t_hold;
    logic [15:0] e;
    do_clear(1'b1);
    @(negedge clk_i);
    xfer_i = 1'b1; rx_byte_i = 8'hC3; crc_en_i = 1'b1; bit_stb_i = 1'b1;
    @(negedge clk_i);
    xfer_i = 1'b0; bit_stb_i = 1'b0;
    check("R6 strobe with transfer", crc_o, 16'hFFFF);
    repeat (5) @(negedge clk_i);
    check("R6 hold without strobe", crc_o, 16'hFFFF);
    strobes(8);
    e = m_bits(16'hFFFF, 8'hC3, 8, 1'b1);
    check("R6 byte after gap", crc_o, e);
    @(negedge clk_i);
    xfer_i = 1'b1; rx_byte_i = 8'h77; crc_en_i = 1'b1; crc_clear_i = 1'b1; bit_stb_i = 1'b1;
    @(negedge clk_i);
    xfer_i = 1'b0; crc_clear_i = 1'b0; bit_stb_i = 1'b0;
    check("R2 clear beats transfer", crc_o, 16'hFFFF);
    strobes(8);
    check("R2 no byte after clear", crc_o, 16'hFFFF);
  endtask

  task automatic t_exclude;
    logic [15:0] e;
    do_clear(1'b1);
    do_xfer(8'h11, 1'b1);
    strobes(8);
    e = m_bits(16'hFFFF, 8'h11, 8, 1'b1);
    do_xfer(8'h22, 1'b0);
    strobes(8);
    check("R4 excluded byte", crc_o, e);
    do_xfer(8'h33, 1'b1);
    strobes(8);
    check("R4 next byte included", crc_o, m_bits(e, 8'h33, 8, 1'b1));
  endtask

  task automatic t_enable_drop;
    do_clear(1'b0);
    do_xfer(8'h96, 1'b1);
    crc_en_i = 1'b0;
    strobes(8);
    check("R9 enable drop mid byte", crc_o, m_bits(16'h0000, 8'h96, 8, 1'b0));
  endtask

  task automatic t_restart;
    logic [15:0] e;
    do_clear(1'b1);
    do_xfer(8'hF0, 1'b1);
    strobes(3);
    e = m_bits(16'hFFFF, 8'hF0, 3, 1'b1);
    do_xfer(8'h0F, 1'b1);
    strobes(8);
    check("R7 restart enabled", crc_o, m_bits(e, 8'h0F, 8, 1'b1));
    do_clear(1'b0);
    do_xfer(8'hB5, 1'b1);
    strobes(2);
    e = m_bits(16'h0000, 8'hB5, 2, 1'b0);
    do_xfer(8'h4C, 1'b0);
    strobes(8);
    check("R7 restart disabled", crc_o, e);
  endtask

  task automatic t_clear_cancel;
    do_clear(1'b1);
    do_xfer(8'hAB, 1'b1);
    strobes(2);
    do_clear(1'b1);
    strobes(6);
    check("R2 clear cancels byte", crc_o, 16'hFFFF);
  endtask

  task automatic t_residue(logic p);
    logic [7:0] msg [4];
    logic [15:0] c;
    msg[0] = 8'h12; msg[1] = 8'hE4; msg[2] = 8'h00; msg[3] = 8'h9D;
    do_clear(p);
    c = p ? 16'hFFFF : 16'h0000;
    for (int i = 0; i < 4; i++) begin
      do_xfer(msg[i], 1'b1);
      strobes(8);
      c = m_bits(c, msg[i], 8, p);
    end
    check("R8 message crc", crc_o, c);
    do_xfer(c[7:0], 1'b1);
    strobes(8);
    do_xfer(c[15:8], 1'b1);
    strobes(8);
    check("R8 residue zero", crc_o, 16'h0000);
    check("R8 ok high", {15'd0, crc_ok_o}, 16'd1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_clear();
    t_single();
    t_hold();
    t_exclude();
    t_enable_drop();
    t_restart();
    t_clear_cancel();
    t_residue(1'b0);
    t_residue(1'b1);
    summary();
    $finish;
  end
endmodule